// File: doc/BRIEF.md
# Stream Handshake Pipeline Stage

This block sits in the middle of a valid/ready stream link that carries a data word and an end-of-packet flag. It cuts a timing path on that link while keeping every beat. Each beat passes through once, in order. One extra holding register, the skid slot, catches the beat that is already in flight when the consumer lowers ready. Because of it, the ready signal going back to the producer can come from a flop and does not have to follow the consumer's ready combinationally.

A build-time parameter selects one of two arrangements. In the ready-cut arrangement only the backward ready path is registered. The forward valid, data and last signals pass straight through when the skid slot is empty, so a beat crosses in zero cycles, or in one cycle after a stall. In the full-cut arrangement every output of the block comes from a flop. A beat then takes one cycle to cross, or two when it has to wait in the skid slot. Data width is a parameter.

Top module: `axis_skid_stage`

## Requirements
- R1: While `rst` (synchronous, active-high) is asserted, the block clears its stored beats. On the first cycle after reset, `s_ready` is 1, and in full-cut mode `m_valid` is 0.
- R2: In ready-cut mode (`MODE` = `SKID_READY_CUT`), when the skid slot is empty, `m_valid`, `m_data` and `m_last` equal `s_valid`, `s_data` and `s_last` in the same cycle (zero latency).
- R3: In ready-cut mode, a beat accepted while `m_ready` is 0 is held. That beat is presented first, and it leaves on the first cycle with `m_ready` = 1. This is one cycle later than it would have left without the stall.
- R4: In full-cut mode (`MODE` = `SKID_FULL_CUT`), all outputs come from flops. A beat accepted at a clock edge with an idle output appears on `m_valid`/`m_data` in the next cycle and not in the same cycle.
- R5: In full-cut mode, a beat accepted while the output beat is stalled goes to the skid slot. It is presented right after the output beat leaves, so it spends at most two cycles in the block once `m_ready` stays high.
- R6: `s_ready` falls only in the cycle after a beat was accepted while the output was stalled. It is 0 exactly while the block holds as many beats as it can store (1 in ready-cut mode, 2 in full-cut mode), and it returns to 1 the cycle after a beat drains.
- R7: For any pattern of `s_valid` and `m_ready`, the beats leave in the order they were accepted. None is lost and none is repeated.
- R8: While `m_valid` is 1 and `m_ready` is 0, the next cycle keeps `m_valid` at 1 with `m_data` and `m_last` unchanged.
- R9: `m_last` always leaves with the data word it was accepted with.
- R10: The number of beats accepted but not yet delivered never exceeds the mode's capacity: 1 for ready-cut, 2 for full-cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Producer has a beat |
| s_data | input | DATA_W | Producer data word |
| s_last | input | 1 | Producer end-of-packet flag |
| s_ready | output | 1 | Registered ready to the producer |
| m_valid | output | 1 | Beat offered to the consumer |
| m_data | output | DATA_W | Data word offered to the consumer |
| m_last | output | 1 | End-of-packet flag offered to the consumer |
| m_ready | input | 1 | Consumer accepts the offered beat |

## Verification
The directed tests target the cycle in which the consumer lowers ready at the same edge that a new beat is accepted. A design that mishandles this either overwrites the beat on the output, so the stalled word changes or vanishes, or takes the in-flight beat nowhere, so a word is lost. The tests then check the order in which the skid beat and the held beat leave. If the design emptied the slots in the wrong order, the words would come out swapped or one would come out twice.

The release cycle of `s_ready` is checked directly. A design that reopens one cycle too late loses throughput, and one that reopens too early accepts a beat it has nowhere to put. A long random phase drives both modes with producers that follow the protocol and checks every delivered word and flag against a model queue. That queue catches any loss, duplication or reordering that the directed cases miss.

// File: rtl/axis_skid_pkg.sv
package axis_skid_pkg;

    typedef enum logic {
        SKID_READY_CUT = 1'b0,
        SKID_FULL_CUT  = 1'b1
    } skid_mode_e;

    // Beats the stage can hold at once in each arrangement
    function automatic int unsigned skid_capacity(skid_mode_e mode);
        return (mode == SKID_FULL_CUT) ? 2 : 1;
    endfunction

    // Cycles a beat spends in the stage without and with a stall
    function automatic int unsigned skid_min_latency(skid_mode_e mode);
        return (mode == SKID_FULL_CUT) ? 1 : 0;
    endfunction

    function automatic int unsigned skid_max_latency(skid_mode_e mode);
        return skid_min_latency(mode) + 1;
    endfunction

endpackage

// File: rtl/skid_slot.sv
module skid_slot #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         drain,
    input  logic [W-1:0] din,
    output logic         full,
    output logic [W-1:0] dout
);
    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (load) begin
                full_q <= 1'b1;
                data_q <= din;
            end else if (drain) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full = full_q;
    assign dout = data_q;
endmodule

// File: rtl/skid_ready_cut.sv
module skid_ready_cut #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_beat,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_beat,
    input  logic         out_ready
);
    logic         rdy_q;
    logic         slot_full;
    logic [W-1:0] slot_beat;
    logic         slot_load;
    logic         slot_drain;
    logic         full_next;

    // Beat accepted while consumer stalls goes into the slot
    assign slot_load  = in_valid && rdy_q && !out_ready;
    assign slot_drain = slot_full && out_ready;
    assign full_next  = slot_load || (slot_full && !out_ready);

    skid_slot #(.W(W)) u_slot (
        .clk   (clk),
        .rst   (rst),
        .load  (slot_load),
        .drain (slot_drain),
        .din   (in_beat),
        .full  (slot_full),
        .dout  (slot_beat)
    );

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b1;
        else     rdy_q <= !full_next;
    end

    assign in_ready  = rdy_q;
    assign out_valid = slot_full || in_valid;
    assign out_beat  = slot_full ? slot_beat : in_beat;
endmodule

// File: rtl/skid_full_cut.sv
module skid_full_cut #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_beat,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_beat,
    input  logic         out_ready
);
    logic         rdy_q;
    logic         ov_q;
    logic [W-1:0] ob_q;
    logic         slot_full;
    logic [W-1:0] slot_beat;
    logic         accept;
    logic         advance;
    logic         slot_load;
    logic         slot_drain;
    logic         full_next;

    assign accept     = in_valid && rdy_q;
    assign advance    = !ov_q || out_ready;
    assign slot_load  = accept && !advance;
    assign slot_drain = slot_full && advance;
    assign full_next  = (slot_full && !advance) || slot_load;

    skid_slot #(.W(W)) u_slot (
        .clk   (clk),
        .rst   (rst),
        .load  (slot_load),
        .drain (slot_drain),
        .din   (in_beat),
        .full  (slot_full),
        .dout  (slot_beat)
    );

    // Output register: refilled from the slot first, then from upstream
    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q <= 1'b0;
            ob_q <= '0;
        end else if (advance) begin
            ov_q <= slot_full || accept;
            if (slot_full)   ob_q <= slot_beat;
            else if (accept) ob_q <= in_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b1;
        else     rdy_q <= !full_next;
    end

    assign in_ready  = rdy_q;
    assign out_valid = ov_q;
    assign out_beat  = ob_q;
endmodule

// File: rtl/axis_skid_stage.sv
module axis_skid_stage
    import axis_skid_pkg::*;
#(
    parameter int         DATA_W = 32,
    parameter skid_mode_e MODE   = SKID_FULL_CUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    input  logic              m_ready
);
    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);

    beat_t in_beat;
    beat_t out_beat;

    assign in_beat.last = s_last;
    assign in_beat.data = s_data;

    generate
        if (MODE == SKID_FULL_CUT) begin : g_full
            skid_full_cut #(.W(BEAT_W)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (s_valid),
                .in_beat   (in_beat),
                .in_ready  (s_ready),
                .out_valid (m_valid),
                .out_beat  (out_beat),
                .out_ready (m_ready)
            );
        end else begin : g_ready
            skid_ready_cut #(.W(BEAT_W)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (s_valid),
                .in_beat   (in_beat),
                .in_ready  (s_ready),
                .out_valid (m_valid),
                .out_beat  (out_beat),
                .out_ready (m_ready)
            );
        end
    endgenerate

    assign m_data = out_beat.data;
    assign m_last = out_beat.last;
endmodule

// File: rtl/axis_skid_checker.sv
module axis_skid_checker
    import axis_skid_pkg::*;
#(
    parameter int         DATA_W = 32,
    parameter skid_mode_e MODE   = SKID_FULL_CUT
) (
    input logic              clk,
    input logic              rst,
    input logic              s_valid,
    input logic [DATA_W-1:0] s_data,
    input logic              s_last,
    input logic              s_ready,
    input logic              m_valid,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last,
    input logic              m_ready
);
    localparam logic [1:0] CAP = 2'(skid_capacity(MODE));

    logic [1:0] occ;
    logic       acc;
    logic       del;

    assign acc = s_valid && s_ready;
    assign del = m_valid && m_ready;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + {1'b0, acc} - {1'b0, del};
    end

    AST_RESET_READY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> s_ready); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CAP); // R10

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R8

    AST_READY_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(s_ready) |-> $past(s_valid && !m_ready)); // R6

    AST_READY_TRACKS_STORE: assert property (@(posedge clk) disable iff (rst)
        s_ready == (occ < CAP)); // R6

    generate
        if (MODE == SKID_FULL_CUT) begin : g_full_chk
            AST_FULL_VALID_REG: assert property (@(posedge clk) disable iff (rst)
                m_valid == (occ != 2'd0)); // R4
        end else begin : g_ready_chk
            AST_RO_PASS: assert property (@(posedge clk) disable iff (rst)
                (occ == 2'd0 && s_valid) |-> (m_valid && m_data == s_data && m_last == s_last)); // R2
        end
    endgenerate
endmodule

bind axis_skid_stage axis_skid_checker #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_last  (m_last),
    .m_ready (m_ready)
);

// File: tb/sim_axis_skid_stage.sv
`timescale 1ns/1ps
module sim_axis_skid_stage;
    import axis_skid_pkg::*;

    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // u0: full-cut, u1: ready-cut
    logic          a_sv = 0, a_sl = 0, a_mr = 0;
    logic [DW-1:0] a_sd = '0;
    logic          a_sr, a_mv, a_ml;
    logic [DW-1:0] a_md;
    logic          b_sv = 0, b_sl = 0, b_mr = 0;
    logic [DW-1:0] b_sd = '0;
    logic          b_sr, b_mv, b_ml;
    logic [DW-1:0] b_md;

    axis_skid_stage #(.DATA_W(DW), .MODE(SKID_FULL_CUT)) u0 (
        .clk(clk), .rst(rst), .s_valid(a_sv), .s_data(a_sd), .s_last(a_sl), .s_ready(a_sr),
        .m_valid(a_mv), .m_data(a_md), .m_last(a_ml), .m_ready(a_mr));

    axis_skid_stage #(.DATA_W(DW), .MODE(SKID_READY_CUT)) u1 (
        .clk(clk), .rst(rst), .s_valid(b_sv), .s_data(b_sd), .s_last(b_sl), .s_ready(b_sr),
        .m_valid(b_mv), .m_data(b_md), .m_last(b_ml), .m_ready(b_mr));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Scoreboards, sampled at the falling edge
    logic [DW:0] qa[$];
    logic [DW:0] qb[$];
    bit sb_on = 0;
    bit a_acc = 0, b_acc = 0;

    always @(negedge clk) begin
        a_acc = !rst && a_sv && a_sr;
        b_acc = !rst && b_sv && b_sr;
        if (!rst && sb_on) begin
            if (a_acc) qa.push_back({a_sl, a_sd});
            if (a_mv && a_mr) begin
                if (qa.size() == 0) chk(0, "R7 u0 extra beat", 32'(a_md), 0);
                else begin
                    logic [DW:0] e;
                    e = qa.pop_front();
                    chk({a_ml, a_md} == e, "R7 R9 u0 beat", 32'({a_ml, a_md}), 32'(e));
                end
            end
            if (b_acc) qb.push_back({b_sl, b_sd});
            if (b_mv && b_mr) begin
                if (qb.size() == 0) chk(0, "R7 u1 extra beat", 32'(b_md), 0);
                else begin
                    logic [DW:0] e;
                    e = qb.pop_front();
                    chk({b_ml, b_md} == e, "R7 R9 u1 beat", 32'({b_ml, b_md}), 32'(e));
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    task automatic t_reset();
        rst = 1;
        repeat (3) step();
        rst = 0;
        step();
        chk(a_sr == 1, "R1 u0 s_ready after reset", 32'(a_sr), 1);
        chk(a_mv == 0, "R1 u0 m_valid after reset", 32'(a_mv), 0);
        chk(b_sr == 1, "R1 u1 s_ready after reset", 32'(b_sr), 1);
    endtask

    task automatic t_ro_pass();
        b_mr = 1; b_sv = 1; b_sd = 16'h1111; b_sl = 1;
        settle();
        chk(b_mv == 1 && b_md == 16'h1111, "R2 u1 same-cycle data", 32'(b_md), 32'h1111);
        chk(b_ml == 1, "R2 u1 same-cycle last", 32'(b_ml), 1);
        step();
        b_sd = 16'h2222; b_sl = 0;
        settle();
        chk(b_md == 16'h2222 && b_sr == 1, "R2 u1 streaming", 32'(b_md), 32'h2222);
        step();
        b_sv = 0;
        settle();
        chk(b_mv == 0, "R2 u1 idle", 32'(b_mv), 0);
    endtask

    task automatic t_ro_stall();
        step();
        b_sv = 1; b_sd = 16'hB0B0; b_sl = 1; b_mr = 0;
        settle();
        chk(b_sr == 1 && b_md == 16'hB0B0, "R2 u1 pre-stall passthrough", 32'(b_md), 32'hB0B0);
        step();
        b_sd = 16'hC0C0; b_sl = 0;
        settle();
        chk(b_sr == 0, "R6 u1 ready low while slot holds", 32'(b_sr), 0);
        chk(b_md == 16'hB0B0 && b_ml == 1, "R3 u1 held beat first", 32'(b_md), 32'hB0B0);
        step();
        b_mr = 1;
        settle();
        chk(b_md == 16'hB0B0 && b_mv == 1, "R3 u1 held beat on release", 32'(b_md), 32'hB0B0);
        step();
        settle();
        chk(b_sr == 1, "R6 u1 ready back after drain", 32'(b_sr), 1);
        chk(b_md == 16'hC0C0 && b_ml == 0, "R3 u1 next beat passes", 32'(b_md), 32'hC0C0);
        step();
        b_sv = 0;
    endtask

    task automatic t_full_latency();
        a_mr = 1; a_sv = 1; a_sd = 16'hA1A1; a_sl = 0;
        settle();
        chk(a_mv == 0, "R4 u0 not same cycle", 32'(a_mv), 0);
        step();
        a_sv = 0;
        settle();
        chk(a_mv == 1 && a_md == 16'hA1A1, "R4 u0 one-cycle latency", 32'(a_md), 32'hA1A1);
        step();
        settle();
        chk(a_mv == 0, "R4 u0 drained", 32'(a_mv), 0);
    endtask

    task automatic t_full_stall();
        a_sv = 1; a_sd = 16'h000B; a_sl = 0; a_mr = 0;
        settle();
        chk(a_sr == 1, "R6 u0 ready while empty", 32'(a_sr), 1);
        step();
        a_sd = 16'h000C; a_sl = 0;
        settle();
        chk(a_mv == 1 && a_md == 16'h000B && a_sr == 1, "R5 u0 first beat out", 32'(a_md), 32'h000B);
        step();
        a_sd = 16'h000D; a_sl = 1;
        settle();
        chk(a_sr == 0, "R6 u0 ready drops after stalled accept", 32'(a_sr), 0);
        chk(a_md == 16'h000B, "R8 u0 output stable in stall", 32'(a_md), 32'h000B);
        step();
        a_mr = 1;
        settle();
        chk(a_md == 16'h000B && a_sr == 0, "R8 u0 still held", 32'(a_md), 32'h000B);
        step();
        settle();
        chk(a_md == 16'h000C && a_sr == 1, "R5 u0 skid beat next", 32'(a_md), 32'h000C);
        step();
        a_sv = 0;
        settle();
        chk(a_md == 16'h000D && a_ml == 1, "R9 u0 last with its word", 32'({a_ml, a_md}), 32'h1000D);
        step();
        settle();
        chk(a_mv == 0, "R7 u0 no repeat", 32'(a_mv), 0);
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        logic [DW-1:0] ca = 1, cb = 1;
        sb_on = 1;
        for (int i = 0; i < 4000; i++) begin
            step();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (!a_sv || a_acc) begin
                a_sv = lf[0] | lf[5];
                if (a_sv) begin a_sd = ca; a_sl = (ca % 5 == 0); ca++; end
            end
            if (!b_sv || b_acc) begin
                b_sv = lf[2] | lf[9];
                if (b_sv) begin b_sd = cb; b_sl = (cb % 3 == 0); cb++; end
            end
            a_mr = (i % 400 < 200) ? (lf[3] | lf[7]) : lf[11];
            b_mr = (i % 400 < 200) ? (lf[4] | lf[8]) : lf[14];
        end
        a_mr = 1; b_mr = 1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (a_acc) a_sv = 0;
            if (b_acc) b_sv = 0;
        end
        settle();
        chk(qa.size() == 0, "R7 u0 all beats delivered", 32'(qa.size()), 0);
        chk(qb.size() == 0, "R7 u1 all beats delivered", 32'(qb.size()), 0);
        chk(ca > 100 && cb > 100, "R10 traffic volume", 32'(ca), 101);
        sb_on = 0;
    endtask

    initial begin
        t_reset();
        t_ro_pass();
        t_ro_stall();
        t_full_latency();
        t_full_stall();
        t_random();
        step();
        finish_run();
    end
endmodule